// File: doc/BRIEF.md
# Timer Event Flag and Interrupt Enable Register

This block is a single byte-wide register on a simple peripheral bus. It holds a sticky event flag and an interrupt enable for each of three timer channels, and it drives one interrupt request per channel. Each channel's general register works either as an output compare or as an input capture, chosen by a per-channel mode input. The flag picks up the compare-match strobe in compare mode and the capture strobe in capture mode.

Software clears a flag with a two-step handshake. It first reads the register while the flag is 1, and then writes 0 to that flag's bit position. Writing 1 to a flag does nothing. A write with no preceding qualifying read leaves the flag set. Each flag keeps a private arm bit that records the qualifying read. Any write to the register uses up every arm bit, whether or not that write clears a flag. The counters, the compare and capture registers, and the interrupt controller are outside this block.

Top module: `tmr_evt_flag_reg`

## Requirements
- R1: After synchronous reset the register reads 0x88: all enables and flags are 0 and both reserved bits are 1. All interrupt requests are 0.
- R2: Bit layout: bits 7 and 3 are reserved, always read 1 and ignore writes. Bits 6, 5 and 4 are the enables of channels 2, 1 and 0. Bits 2, 1 and 0 are the flags of channels 2, 1 and 0.
- R3: An addressed write loads bits 6..4 into the three enables. An addressed read returns them unchanged.
- R4: Writing 1 to a flag bit never sets or clears that flag.
- R5: A flag clears only on an addressed write with 0 in its bit, and only when an earlier addressed read returned 1 in that bit with no other addressed write in between. Any addressed write disarms all flags.
- R6: With cap_mode bit n = 0, channel n's flag sets on cmp_match[n], and cap_strobe[n] is ignored.
- R7: With cap_mode bit n = 1, channel n's flag sets on cap_strobe[n], and cmp_match[n] is ignored.
- R8: A set event and a clearing write on the same flag in the same cycle leave the flag at 1.
- R9: irq_req[n] equals flag n AND enable n as they stood one cycle earlier (a registered output).
- R10: The register answers only at byte address 0xFFF65. Accesses at any other address change nothing, and reads there return 0x00. An addressed read returns the register value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of an addressed read, else 0 |
| cmp_match | input | 3 | Per-channel counter-equals-register strobe |
| cap_strobe | input | 3 | Per-channel capture-transfer strobe |
| cap_mode | input | 3 | Per-channel mode: 1 input capture, 0 output compare |
| irq_req | output | 3 | Per-channel registered interrupt request |

## Verification
Assertions check the per-flag rules on every cycle. A selected event always leaves the flag at 1 on the next cycle, which also covers the set-wins race. A cleared flag never rises without an event. An unarmed flag never falls. Every addressed write leaves all arm bits clear. Other assertions check that the reserved bits read 1, that unaddressed writes leave the enables alone, and that the request registers track flag and enable.

Some behaviours can be shown only by the bench's scenarios. These are the full read-then-write-0 handshake across cycles, the way an intervening write of 1 uses up the arm, the mode steering of the two strobes, and the exact read values at the register's address and at other addresses.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    localparam int NUM_CH    = 3;
    localparam int REG_W     = 8;
    localparam int ADDR_W    = 20;
    localparam logic [ADDR_W-1:0] REG_ADDR = 20'hFFF65;
    localparam int FLAG_LSB  = 0;
    localparam int EN_LSB    = 4;
    localparam int RSV_LO    = 3;
    localparam int RSV_HI    = 7;
    localparam logic [REG_W-1:0] RSV_MASK = (REG_W'(1) << RSV_LO) | (REG_W'(1) << RSV_HI);

    typedef logic [NUM_CH-1:0] ch_vec_t;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [REG_W-1:0] wdata;
    } bus_acc_t;

    function automatic logic [REG_W-1:0] pack_status(input ch_vec_t en, input ch_vec_t flg);
        logic [REG_W-1:0] v;
        v = RSV_MASK;
        v[EN_LSB +: NUM_CH]   = en;
        v[FLAG_LSB +: NUM_CH] = flg;
        return v;
    endfunction
endpackage

// File: rtl/tmr_evt_select.sv
module tmr_evt_select
    import tmr_irq_pkg::*;
(
    input  ch_vec_t cmp_match,
    input  ch_vec_t cap_strobe,
    input  ch_vec_t cap_mode,
    output ch_vec_t evt
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            if (cap_mode[c]) evt[c] = cap_strobe[c];
            else             evt[c] = cmp_match[c];
        end
    end
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wbit,
    output logic flag_q,
    output logic arm_q
);
    logic clr_req;
    logic flag_d;
    logic arm_d;

    always_comb begin
        clr_req = wr_hit && arm_q && !wbit;
        flag_d  = evt || (flag_q && !clr_req);
        if (wr_hit)      arm_d = 1'b0;
        else if (rd_hit) arm_d = arm_q || flag_q;
        else             arm_d = arm_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            arm_q  <= arm_d;
        end
    end

    // R6 R7 R8: a selected event always leaves the flag set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        evt |=> flag_q);
    // R4: nothing but an event raises a flag
    a_r4_no_set_by_write: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && !evt) |=> !flag_q);
    // R5: an unarmed flag cannot be cleared
    a_r5_clear_needs_arm: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !arm_q) |=> flag_q);
    // R5: any write disarms
    a_r5_arm_consumed: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> !arm_q);
endmodule

// File: rtl/tmr_irq_out.sv
module tmr_irq_out
    import tmr_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ch_vec_t flag,
    input  ch_vec_t en,
    output ch_vec_t irq_q
);
    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= flag & en;
    end

    // R9: request follows flag and enable with one register delay
    a_r9_irq_lag: assert property (@(posedge clk) disable iff (rst)
        (flag == '0 || en == '0) |=> irq_q == '0);
endmodule

// File: rtl/tmr_evt_flag_reg.sv
module tmr_evt_flag_reg
    import tmr_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0] cmp_match,
    input  logic [NUM_CH-1:0] cap_strobe,
    input  logic [NUM_CH-1:0] cap_mode,
    output logic [NUM_CH-1:0] irq_req
);
    bus_acc_t acc;
    logic     addr_hit;
    logic     rd_hit;
    logic     wr_hit;
    ch_vec_t  en_q;
    ch_vec_t  flag_q;
    ch_vec_t  arm_q;
    ch_vec_t  evt;
    logic     rsv_wbits_unused;

    always_comb begin
        acc.rd    = bus_rd;
        acc.wr    = bus_wr;
        acc.wdata = bus_wdata;
        addr_hit  = (bus_addr == REG_ADDR);
        rd_hit    = addr_hit && acc.rd;
        wr_hit    = addr_hit && acc.wr;
        rsv_wbits_unused = ^(acc.wdata & RSV_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst)         en_q <= '0;
        else if (wr_hit) en_q <= acc.wdata[EN_LSB +: NUM_CH];
    end

    tmr_evt_select u_sel (
        .cmp_match (cmp_match),
        .cap_strobe(cap_strobe),
        .cap_mode  (cap_mode),
        .evt       (evt)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
        tmr_flag_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .evt   (evt[c]),
            .rd_hit(rd_hit),
            .wr_hit(wr_hit),
            .wbit  (acc.wdata[FLAG_LSB + c]),
            .flag_q(flag_q[c]),
            .arm_q (arm_q[c])
        );
    end

    tmr_irq_out u_irq (
        .clk  (clk),
        .rst  (rst),
        .flag (flag_q),
        .en   (en_q),
        .irq_q(irq_req)
    );

    always_comb begin
        if (rd_hit) bus_rdata = pack_status(en_q, flag_q);
        else        bus_rdata = '0;
    end

    // R1: reset clears enables and flags
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (en_q == '0 && flag_q == '0 && arm_q == '0));
    // R2: reserved bits read back as 1
    a_r2_rsv_ones: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> (bus_rdata[RSV_HI] && bus_rdata[RSV_LO]));
    // R10: writes elsewhere leave the enables alone
    a_r10_miss_keeps_en: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr || bus_addr != REG_ADDR) |=> $stable(en_q));
    // R3: addressed write loads the enables
    a_r3_en_load: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_ADDR) |=> en_q == $past(bus_wdata[EN_LSB +: NUM_CH]));
endmodule

// File: tb/tmr_evt_flag_reg_tb_top.sv
module tmr_evt_flag_reg_tb_top;
    localparam logic [19:0] HIT  = 20'hFFF65;
    localparam logic [19:0] MISS = 20'hFFF64;

    logic        clk = 1'b0;
    logic        rst;
    logic [19:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [2:0]  cmp_match, cap_strobe, cap_mode, irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [2:0] m_flag, m_en, m_arm, m_irq;

    always #2 clk = ~clk;

    tmr_evt_flag_reg dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_match(cmp_match),
        .cap_strobe(cap_strobe), .cap_mode(cap_mode), .irq_req(irq_req)
    );

    function automatic logic [7:0] exp_read(input logic [19:0] a, input logic [2:0] en, input logic [2:0] fl);
        if (a != HIT) return 8'h00;
        return {1'b1, en, 1'b1, fl};
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic [19:0] a, input logic r, input logic w, input logic [7:0] d,
                         input logic [2:0] cm, input logic [2:0] cp, input string tag);
        logic [2:0] evt, clr, old_flag;
        bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
        cmp_match = cm; cap_strobe = cp;
        #1;
        if (r) chk(bus_rdata, exp_read(a, m_en, m_flag), tag);
        @(posedge clk);
        old_flag = m_flag;
        m_irq = m_flag & m_en;
        evt = (cap_mode & cp) | (~cap_mode & cm);
        clr = (a == HIT && w) ? (m_arm & ~d[2:0]) : 3'b000;
        m_flag = evt | (m_flag & ~clr);
        if (a == HIT && w) begin
            m_en  = d[6:4];
            m_arm = 3'b000;
        end else if (a == HIT && r) begin
            m_arm = m_arm | old_flag;
        end
        @(negedge clk);
        chk({5'b0, irq_req}, {5'b0, m_irq}, "R9");
        bus_rd = 1'b0; bus_wr = 1'b0; cmp_match = 3'b0; cap_strobe = 3'b0;
    endtask

    task automatic rd_lit(input logic [19:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        #1;
        chk(bus_rdata, exp, tag);
        cycle(a, 1'b1, 1'b0, 8'h00, 3'b0, 3'b0, tag);
    endtask

    task automatic wr(input logic [7:0] d);
        cycle(HIT, 1'b0, 1'b1, d, 3'b0, 3'b0, "R5");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7722));
        rst = 1'b1; bus_addr = HIT; bus_rd = 0; bus_wr = 0; bus_wdata = 0;
        cmp_match = 0; cap_strobe = 0; cap_mode = 0;
        m_flag = 0; m_en = 0; m_arm = 0; m_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk({5'b0, irq_req}, 8'h00, "R1");
        rd_lit(HIT, 8'h88, "R1");
        wr(8'hFF);
        rd_lit(HIT, 8'hF8, "R3 and R4");
        wr(8'h00);
        rd_lit(HIT, 8'h88, "R2");
        cap_mode = 3'b000;
        cycle(HIT, 0, 0, 8'h00, 3'b001, 3'b010, "R6");
        rd_lit(HIT, 8'h89, "R6");
        cap_mode = 3'b110;
        cycle(HIT, 0, 0, 8'h00, 3'b100, 3'b010, "R7");
        rd_lit(HIT, 8'h8B, "R7");
        wr(8'h8F);
        wr(8'h80);
        rd_lit(HIT, 8'h8B, "R5 unarmed");
        wr(8'h81);
        rd_lit(HIT, 8'h89, "R5 clear one");
        cycle(HIT, 0, 1, 8'h88, 3'b001, 3'b000, "R8");
        rd_lit(HIT, 8'h89, "R8");
        wr(8'h88);
        rd_lit(HIT, 8'h88, "R5 cleared");
        wr(8'h10);
        cycle(HIT, 0, 0, 8'h00, 3'b001, 3'b000, "R9");
        chk({5'b0, irq_req}, 8'h00, "R9 lag");
        cycle(HIT, 0, 0, 8'h00, 3'b000, 3'b000, "R9");
        chk({5'b0, irq_req}, 8'h01, "R9 set");
        rd_lit(MISS, 8'h00, "R10");
        cycle(MISS, 0, 1, 8'h00, 3'b0, 3'b0, "R10");
        rd_lit(HIT, 8'h99, "R10");
        for (int i = 0; i < 600; i++) begin
            logic [19:0] a;
            logic r, w;
            a = ($urandom_range(0, 9) == 0) ? MISS : HIT;
            r = ($urandom_range(0, 2) == 0);
            w = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 15) == 0) cap_mode = 3'($urandom);
            cycle(a, r, w, 8'($urandom),
                  3'($urandom) & 3'($urandom), 3'($urandom) & 3'($urandom), "R2 R5 R6 R7");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule